// File: doc/BRIEF.md
# Output Enable and Protection Gating

This block turns three kinds of control into the final on/off gate level for five regulators and three high-side drivers. The three kinds are the external enable pin, the control byte held by the serial-bus slave, and the protection status. Protection status covers two inputs. The first is a digitized die temperature, an unsigned code in whole degrees Celsius. The second is a battery-overvoltage flag.

Thermal shutdown has two groups, and each group has its own hysteresis state machine. The 2 A driver, HSD1, uses a wider window than all the other outputs. An overvoltage condition turns every output off. Current limiting is handled elsewhere and never reaches this block, so it never removes an output. The REG4 voltage-select level goes straight from the control byte to the output.

Top module: `out_gate_ctrl`

## Requirements
- R1: While reset is asserted and after it, `gate_o` is all zero and `fault_o` is all zero, until an input causes a change.
- R2: Gate bit order is [0]=REG1, [1]=REG2, [2]=REG3, [3]=REG4, [4]=REG5, [5]=HSD1, [6]=HSD2, [7]=HSD3. REG2 and REG3 follow the enable pin alone: if the pin is 1 (with no fault or overvoltage) they are on, and if the pin is 0 they are off. This holds one cycle after the pin changes.
- R3: Control byte bits are [7]=REG1, [6]=REG4, [5]=REG4 select, [4]=REG5, [3]=HSD1, [2]=HSD2, [1]=HSD3. While the enable pin is 1, each bus-controlled gate follows its bit one cycle later. While the pin is 0, every gate is 0.
- R4: Dropping the enable pin does not clear the bus-controlled requests. When the pin returns to 1, the gates take the unchanged control byte again one cycle later.
- R5: The main group (REG1 to REG5, HSD2, HSD3) enters shutdown at a temperature code of 160 or more. One cycle later, the main group's fault flags are 1 and its gates are 0.
- R6: The main group leaves shutdown at a code of 130 or less. For codes from 131 to 159, the group keeps its present state.
- R7: The HSD1 group enters shutdown at a code of 170 or more and leaves at 120 or less. Between those values it keeps its state. Its fault flag is `fault_o[5]`, and it follows the same one-cycle timing.
- R8: While `ovp_i` is 1, all gates are 0 one cycle later, and the fault flags are not affected.
- R9: `reg4_hi_sel_o` equals control bit [5] in the same cycle, whatever the enable, thermal or overvoltage state.
- R10: Control bit [0] has no effect on any gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_pin_i | input | 1 | External enable pin level |
| ctrl_reg_i | input | 8 | Control byte held by the serial-bus slave |
| temp_code_i | input | 8 | Die temperature code, degrees Celsius |
| ovp_i | input | 1 | Battery overvoltage indication |
| gate_o | output | 8 | Final on/off gate per output |
| reg4_hi_sel_o | output | 1 | REG4 high-voltage select |
| fault_o | output | 8 | Per-output thermal-shutdown flag, same bit order as gate_o |

## Verification
Every gate and fault result is registered exactly once. A change at the inputs therefore shows at the outputs after the next rising edge, and the thermal state machines add no extra cycle because the gates are built from their next state. The REG4 select has no register and must match within the same cycle.

The driver applies each stimulus at a falling edge and queues the expected gate and fault words. The monitor pops and compares one item a moment after each rising edge. The select output is compared inside the driver one time unit after it drives the inputs.

// File: rtl/pwr_gate_pkg.sv
package pwr_gate_pkg;
  localparam int NUM_CH  = 8;
  localparam int NUM_GRP = 2;
  localparam int GRP_STD = 0;
  localparam int GRP_HI  = 1;

  localparam int CH_REG1 = 0;
  localparam int CH_REG2 = 1;
  localparam int CH_REG3 = 2;
  localparam int CH_REG4 = 3;
  localparam int CH_REG5 = 4;
  localparam int CH_HSD1 = 5;
  localparam int CH_HSD2 = 6;
  localparam int CH_HSD3 = 7;

  // control byte positions, fixed by the bus slave decode
  localparam int CB_VSEL = 5;

  typedef enum logic {TH_NORMAL = 1'b0, TH_SHUTDOWN = 1'b1} th_state_e;

  function automatic int grp_of(input int ch);
    return (ch == CH_HSD1) ? GRP_HI : GRP_STD;
  endfunction

  // -1: channel not bus controlled
  function automatic int ctrl_bit(input int ch);
    case (ch)
      CH_REG1: return 7;
      CH_REG4: return 6;
      CH_REG5: return 4;
      CH_HSD1: return 3;
      CH_HSD2: return 2;
      CH_HSD3: return 1;
      default: return -1;
    endcase
  endfunction
endpackage

// File: rtl/thermal_hyst.sv
module thermal_hyst
  import pwr_gate_pkg::*;
#(
  parameter int TEMP_W = 8,
  parameter int TRIP   = 160,
  parameter int REL    = 130
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              trip_d_o,
  output logic              trip_q_o
);
  localparam logic [TEMP_W-1:0] TRIP_C = TEMP_W'(TRIP);
  localparam logic [TEMP_W-1:0] REL_C  = TEMP_W'(REL);

  th_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      TH_NORMAL:   if (temp_i >= TRIP_C) state_d = TH_SHUTDOWN;
      TH_SHUTDOWN: if (temp_i <= REL_C)  state_d = TH_NORMAL;
      default:     state_d = TH_NORMAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= TH_NORMAL;
    else         state_q <= state_d;
  end

  assign trip_d_o = (state_d == TH_SHUTDOWN);
  assign trip_q_o = (state_q == TH_SHUTDOWN);
endmodule

// File: rtl/gate_combiner.sv
module gate_combiner
  import pwr_gate_pkg::*;
(
  input  logic               en_i,
  input  logic [7:0]         ctrl_i,
  input  logic               ovp_i,
  input  logic [NUM_GRP-1:0] grp_off_i,
  output logic [NUM_CH-1:0]  gate_d_o
);
  logic [NUM_CH-1:0] req;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    if (ctrl_bit(ch) < 0) begin : g_pin
      assign req[ch] = 1'b1;
    end else begin : g_bus
      assign req[ch] = ctrl_i[ctrl_bit(ch)];
    end
    assign gate_d_o[ch] = en_i & req[ch] & ~ovp_i & ~grp_off_i[grp_of(ch)];
  end
endmodule

// File: rtl/out_gate_ctrl.sv
module out_gate_ctrl
  import pwr_gate_pkg::*;
#(
  parameter int TEMP_W   = 8,
  parameter int STD_TRIP = 160,
  parameter int STD_REL  = 130,
  parameter int HI_TRIP  = 170,
  parameter int HI_REL   = 120
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_pin_i,
  input  logic [7:0]        ctrl_reg_i,
  input  logic [TEMP_W-1:0] temp_code_i,
  input  logic              ovp_i,
  output logic [NUM_CH-1:0] gate_o,
  output logic              reg4_hi_sel_o,
  output logic [NUM_CH-1:0] fault_o
);
  logic [NUM_GRP-1:0] trip_d, trip_q;
  logic [NUM_CH-1:0]  gate_d;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int TR = (g == GRP_HI) ? HI_TRIP : STD_TRIP;
    localparam int RL = (g == GRP_HI) ? HI_REL  : STD_REL;
    thermal_hyst #(.TEMP_W(TEMP_W), .TRIP(TR), .REL(RL)) u_th (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .temp_i   (temp_code_i),
      .trip_d_o (trip_d[g]),
      .trip_q_o (trip_q[g])
    );
  end

  gate_combiner u_comb (
    .en_i      (en_pin_i),
    .ctrl_i    (ctrl_reg_i),
    .ovp_i     (ovp_i),
    .grp_off_i (trip_d),
    .gate_d_o  (gate_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_o <= '0;
    else         gate_o <= gate_d;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_flt
    assign fault_o[ch] = trip_q[grp_of(ch)];
  end

  assign reg4_hi_sel_o = ctrl_reg_i[CB_VSEL];
endmodule

// File: rtl/out_gate_ctrl_chk.sv
module out_gate_ctrl_chk #(
  parameter int TEMP_W   = 8,
  parameter int STD_TRIP = 160,
  parameter int STD_REL  = 130,
  parameter int HI_TRIP  = 170,
  parameter int HI_REL   = 120
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_pin_i,
  input logic              ovp_i,
  input logic [TEMP_W-1:0] temp_code_i,
  input logic [7:0]        gate_o,
  input logic [7:0]        fault_o
);
  localparam logic [TEMP_W-1:0] ST = TEMP_W'(STD_TRIP);
  localparam logic [TEMP_W-1:0] SR = TEMP_W'(STD_REL);
  localparam logic [TEMP_W-1:0] HT = TEMP_W'(HI_TRIP);

  AST_EN_LOW_ALL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_pin_i) |-> gate_o == 8'h00); // R3

  AST_OVP_ALL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ovp_i) |-> gate_o == 8'h00); // R8

  AST_STD_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(temp_code_i >= ST) |-> (fault_o[0] && gate_o[4:0] == 5'b0 && gate_o[7:6] == 2'b0)); // R5

  AST_STD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(temp_code_i > SR && temp_code_i < ST) |-> $stable(fault_o[0])); // R6

  AST_HI_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(temp_code_i >= HT) |-> (fault_o[5] && !gate_o[5])); // R7

  AST_FAULT_BLOCKS_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o & fault_o) == 8'h00); // R5
endmodule

bind out_gate_ctrl out_gate_ctrl_chk #(
  .TEMP_W(TEMP_W), .STD_TRIP(STD_TRIP), .STD_REL(STD_REL),
  .HI_TRIP(HI_TRIP), .HI_REL(HI_REL)
) u_chk (.*);

// File: tb/out_gate_ctrl_bench.sv
module out_gate_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0] gate;
    logic [7:0] fault;
    string      tag;
  } exp_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_pin_i = 1'b0;
  logic [7:0] ctrl_reg_i = 8'h00;
  logic [7:0] temp_code_i = 8'd25;
  logic       ovp_i = 1'b0;
  logic [7:0] gate_o, fault_o;
  logic       reg4_hi_sel_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  exp_t sb[$];
  bit m_std = 0, m_hi = 0;

  out_gate_ctrl u_out_gate_ctrl (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp_v);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  // drive one cycle of stimulus, queue the result due after the next rising edge
  task automatic step(input logic en, input logic [7:0] rg, input logic [7:0] t,
                      input logic ov, input string tag);
    exp_t e;
    logic [7:0] req;
    @(negedge clk_i);
    en_pin_i = en; ctrl_reg_i = rg; temp_code_i = t; ovp_i = ov;
    if (!m_std) m_std = (t >= 8'd160); else m_std = !(t <= 8'd130);
    if (!m_hi)  m_hi  = (t >= 8'd170); else m_hi  = !(t <= 8'd120);
    req = {rg[1], rg[2], rg[3], rg[4], rg[6], 1'b1, 1'b1, rg[7]};
    e.fault = {m_std, m_std, m_hi, m_std, m_std, m_std, m_std, m_std};
    e.gate  = (en && !ov) ? (req & ~e.fault) : 8'h00;
    e.tag = tag;
    sb.push_back(e);
    #1 chk("R9 sel", {7'b0, reg4_hi_sel_o}, {7'b0, rg[5]});
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk_i);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " gate"}, gate_o, e.gate);
        chk({e.tag, " fault"}, fault_o, e.fault);
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    en_pin_i = 1; ctrl_reg_i = 8'hFF;
    repeat (3) @(posedge clk_i);
    #1 chk("R1 reset gate", gate_o, 8'h00);
    chk("R1 reset fault", fault_o, 8'h00);
    @(negedge clk_i); en_pin_i = 0; rst_ni = 1;
    #1 chk("R1 after release", gate_o, 8'h00);

    step(0, 8'hFF, 8'd25, 0, "R3 en low forces off");
    step(1, 8'h00, 8'd25, 0, "R2 pin only");
    step(0, 8'h00, 8'd25, 0, "R2 pin off");
    step(1, 8'hFE, 8'd25, 0, "R3 all bus on");
    step(1, 8'h81, 8'd25, 0, "R10 bit0 ignored reg1");
    step(1, 8'h01, 8'd25, 0, "R10 bit0 alone");
    step(1, 8'h54, 8'd25, 0, "R3 pattern 54");
    step(1, 8'h4A, 8'd25, 0, "R3 pattern 4A");
    step(0, 8'hDE, 8'd25, 0, "R4 en dropped");
    step(0, 8'hDE, 8'd25, 0, "R4 still low");
    step(1, 8'hDE, 8'd25, 0, "R4 restored");
    step(1, 8'hFF, 8'd25, 1, "R8 ovp");
    step(1, 8'hFF, 8'd25, 0, "R8 ovp gone");
    step(1, 8'hFF, 8'd159, 0, "R5 below trip");
    step(1, 8'hFF, 8'd160, 0, "R5 std trip");
    step(1, 8'hFF, 8'd150, 0, "R6 hold 150");
    step(1, 8'hFF, 8'd131, 0, "R6 hold 131");
    step(1, 8'hFF, 8'd130, 0, "R6 release 130");
    step(1, 8'hFF, 8'd169, 0, "R7 hi not tripped");
    step(1, 8'hFF, 8'd170, 0, "R7 hi trip");
    step(1, 8'hFF, 8'd135, 1, "R8 ovp keeps faults");
    step(1, 8'hFF, 8'd130, 0, "R7 std released hi held");
    step(1, 8'hFF, 8'd121, 0, "R7 hold 121");
    step(1, 8'hFF, 8'd120, 0, "R7 release 120");
    step(0, 8'h20, 8'd25, 1, "R9 sel with en low");
    step(1, 8'hDF, 8'd25, 0, "R9 sel clear");
    step(1, 8'hFF, 8'd255, 0, "R5 max code");
    step(1, 8'hFF, 8'd0, 0, "R7 min code");
    repeat (3) @(posedge clk_i);
    #2;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule